// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Router

This block decides where a CAN frame that has just been received should go. A frame sits in a temporary staging buffer and is announced by a one-cycle strobe. The block compares the frame's identifier against an eight-entry receive-queue ID table and against sixteen regular receive mailboxes, using acceptance masks. It then issues one routing command that tells the copy engine to move the staged frame into the queue, into one mailbox, or nowhere.

When the receive queue is enabled, the queue ID table is searched first. Mailboxes 0 to 7 leave the search because their storage belongs to the queue. In shared-mask mode, a global mask covers most slots. A dedicated mask A serves mailbox 14 and queue table entry 6, and a dedicated mask B serves mailbox 15 and table entry 7. In individual-mask mode, every slot has its own mask.

Frames arrive on a plain strobe and the routing result leaves as a plain one-cycle pulse. Neither side has back-pressure. The block accepts one frame per clock and never stalls. The consumer must act on every routing pulse in the cycle it appears.

Top module: `can_rx_filter_router`

## Requirements
- R1: Each cycle in which `frame_valid` is high produces exactly one `route_valid` pulse on the next cycle. `route_valid` is low in every other cycle and is low during and after reset.
- R2: A slot matches when its IDE bit equals the frame's IDE bit and every ID bit whose mask bit is 1 is equal. Mask bits of 0 are don't-care. For standard frames (IDE=0), only ID bits [10:0] are compared.
- R3: With the queue enabled and not full, any matching table entry routes the frame to the queue (`route_dest`=2'b01). `route_idx` is the lowest matching entry, and mailboxes are not considered.
- R4: In shared-mask mode, table entries 0 to 5 use the global mask, entry 6 uses mask A and entry 7 uses mask B.
- R5: In shared-mask mode, mailbox 14 uses mask A, mailbox 15 uses mask B, and every other mailbox uses the global mask.
- R6: In individual-mask mode, table entry k uses individual mask k and mailbox i uses individual mask i. The global mask, mask A and mask B have no effect.
- R7: With the queue disabled, the table is ignored, no frame is routed to the queue, and mailboxes 0 to 7 are searched like any other mailbox.
- R8: With the queue enabled, mailboxes 0 to 7 are never selected.
- R9: While `queue_full` is high, a frame is not routed to the queue, even if a table entry matches. It goes to the lowest matching enabled mailbox numbered 8 or above, or it is dropped.
- R10: Among matching mailboxes, the lowest-numbered enabled one wins (`route_dest`=2'b10, `route_idx`=mailbox number). Disabled mailboxes never match.
- R11: A frame that matches nothing gives `route_dest`=2'b00 and `route_idx`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | Staged frame ready for routing (one cycle per frame) |
| frame_id | input | 29 | Staged frame identifier; standard IDs in bits [10:0] |
| frame_ide | input | 1 | 1 = extended frame, 0 = standard frame |
| queue_en | input | 1 | Receive queue enabled |
| indiv_mask_mode | input | 1 | 1 = per-slot masks, 0 = shared masks |
| queue_full | input | 1 | Receive queue cannot take another frame |
| glob_mask | input | 29 | Shared global acceptance mask |
| mask_a | input | 29 | Shared mask for mailbox 14 / table entry 6 |
| mask_b | input | 29 | Shared mask for mailbox 15 / table entry 7 |
| indiv_masks | input | 464 | Per-slot masks, slot i at bits [29*i +: 29] |
| tbl_ids | input | 232 | Queue table IDs, entry k at bits [29*k +: 29] |
| tbl_ide | input | 8 | Queue table IDE bits |
| mb_ids | input | 464 | Mailbox IDs, mailbox i at bits [29*i +: 29] |
| mb_ide | input | 16 | Mailbox IDE bits |
| mb_en | input | 16 | Mailbox receive enables |
| route_valid | output | 1 | Routing command pulse |
| route_dest | output | 2 | 00 none, 01 queue, 10 mailbox |
| route_idx | output | 4 | Table entry or mailbox number; 0 for none |

## Verification
The bench builds the block with its defaults: 16 mailboxes, an 8-entry table and 29-bit IDs. This count is large enough to put both dedicated-mask mailboxes, 14 and 15, above the queue region and to leave eight mailboxes that stay searchable while the queue is on or full. Directed frames hit the mask-A and mask-B slots, the queue/mailbox overlap, the full-queue fallback and the IDE and standard-ID cases. A randomized phase then draws IDs close to the configured ones, so that several slots match at once and the priority rules are exercised.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;
  typedef enum logic [1:0] {
    DEST_NONE  = 2'b00,
    DEST_QUEUE = 2'b01,
    DEST_MBOX  = 2'b10
  } route_dest_e;

  localparam int STD_ID_W = 11;
endpackage

// File: rtl/can_id_match.sv
module can_id_match #(
  parameter int IDW   = 29,
  parameter int STD_W = 11
) (
  input  logic [IDW-1:0] rx_id,
  input  logic           rx_ide,
  input  logic [IDW-1:0] ent_id,
  input  logic           ent_ide,
  input  logic [IDW-1:0] mask,
  output logic           hit
);
  logic [IDW-1:0] eff_mask;

  always_comb begin
    // standard frames compare only the low identifier field
    eff_mask = ent_ide ? mask : {{(IDW-STD_W){1'b0}}, mask[STD_W-1:0]};
    hit      = (rx_ide == ent_ide) && (((rx_id ^ ent_id) & eff_mask) == '0);
  end
endmodule

// File: rtl/can_mask_sel.sv
module can_mask_sel #(
  parameter int N        = 16,
  parameter int IDW      = 29,
  parameter bit IS_TABLE = 1'b0,
  parameter int A_IDX    = 14,
  parameter int B_IDX    = 15
) (
  input  logic             indiv_mode,
  input  logic [IDW-1:0]   glob_mask,
  input  logic [IDW-1:0]   mask_a,
  input  logic [IDW-1:0]   mask_b,
  input  logic [N*IDW-1:0] indiv,
  output logic [N*IDW-1:0] sel
);
  // slot that takes mask A / mask B in shared mode
  localparam int SLOT_A = IS_TABLE ? N - 2 : A_IDX;
  localparam int SLOT_B = IS_TABLE ? N - 1 : B_IDX;

  for (genvar s = 0; s < N; s++) begin : g_slot
    logic [IDW-1:0] shared;
    if (s == SLOT_A) begin : g_a
      assign shared = mask_a;
    end else if (s == SLOT_B) begin : g_b
      assign shared = mask_b;
    end else begin : g_glob
      assign shared = glob_mask;
    end
    assign sel[s*IDW +: IDW] = indiv_mode ? indiv[s*IDW +: IDW] : shared;
  end
endmodule

// File: rtl/can_prio_pick.sv
module can_prio_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/can_rx_filter_router.sv
module can_rx_filter_router
  import can_rxf_pkg::*;
#(
  parameter int IDW    = 29,
  parameter int NUM_MB = 16,
  parameter int TBL    = 8,
  parameter int A_IDX  = 14,
  parameter int B_IDX  = 15,
  localparam int IDXW  = $clog2(NUM_MB),
  localparam int TIW   = $clog2(TBL)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_valid,
  input  logic [IDW-1:0]        frame_id,
  input  logic                  frame_ide,
  input  logic                  queue_en,
  input  logic                  indiv_mask_mode,
  input  logic                  queue_full,
  input  logic [IDW-1:0]        glob_mask,
  input  logic [IDW-1:0]        mask_a,
  input  logic [IDW-1:0]        mask_b,
  input  logic [NUM_MB*IDW-1:0] indiv_masks,
  input  logic [TBL*IDW-1:0]    tbl_ids,
  input  logic [TBL-1:0]        tbl_ide,
  input  logic [NUM_MB*IDW-1:0] mb_ids,
  input  logic [NUM_MB-1:0]     mb_ide,
  input  logic [NUM_MB-1:0]     mb_en,
  output logic                  route_valid,
  output logic [1:0]            route_dest,
  output logic [IDXW-1:0]       route_idx
);
  logic [TBL*IDW-1:0]    tbl_masks;
  logic [NUM_MB*IDW-1:0] mb_masks;
  logic [TBL-1:0]        tbl_hit;
  logic [NUM_MB-1:0]     mb_hit;
  logic [NUM_MB-1:0]     mb_allow;
  logic [NUM_MB-1:0]     mb_req;
  logic                  tbl_any, mb_any, to_queue;
  logic [TIW-1:0]        tbl_idx;
  logic [IDXW-1:0]       mb_idx;
  route_dest_e           nxt_dest;
  logic [IDXW-1:0]       nxt_idx;

  can_mask_sel #(.N(TBL), .IDW(IDW), .IS_TABLE(1'b1), .A_IDX(A_IDX), .B_IDX(B_IDX))
    u_tbl_mask (
      .indiv_mode(indiv_mask_mode), .glob_mask(glob_mask), .mask_a(mask_a),
      .mask_b(mask_b), .indiv(indiv_masks[TBL*IDW-1:0]), .sel(tbl_masks));

  can_mask_sel #(.N(NUM_MB), .IDW(IDW), .IS_TABLE(1'b0), .A_IDX(A_IDX), .B_IDX(B_IDX))
    u_mb_mask (
      .indiv_mode(indiv_mask_mode), .glob_mask(glob_mask), .mask_a(mask_a),
      .mask_b(mask_b), .indiv(indiv_masks), .sel(mb_masks));

  for (genvar k = 0; k < TBL; k++) begin : g_tbl
    can_id_match #(.IDW(IDW), .STD_W(STD_ID_W)) u_cmp (
      .rx_id(frame_id), .rx_ide(frame_ide),
      .ent_id(tbl_ids[k*IDW +: IDW]), .ent_ide(tbl_ide[k]),
      .mask(tbl_masks[k*IDW +: IDW]), .hit(tbl_hit[k]));
  end

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    can_id_match #(.IDW(IDW), .STD_W(STD_ID_W)) u_cmp (
      .rx_id(frame_id), .rx_ide(frame_ide),
      .ent_id(mb_ids[i*IDW +: IDW]), .ent_ide(mb_ide[i]),
      .mask(mb_masks[i*IDW +: IDW]), .hit(mb_hit[i]));
    // low mailboxes hand their storage to the queue when it is on
    if (i < TBL) begin : g_low
      assign mb_allow[i] = mb_en[i] & ~queue_en;
    end else begin : g_high
      assign mb_allow[i] = mb_en[i];
    end
  end

  assign mb_req = mb_hit & mb_allow;

  can_prio_pick #(.N(TBL), .IW(TIW)) u_tbl_pick (
    .req(tbl_hit & {TBL{queue_en}}), .any(tbl_any), .idx(tbl_idx));

  can_prio_pick #(.N(NUM_MB), .IW(IDXW)) u_mb_pick (
    .req(mb_req), .any(mb_any), .idx(mb_idx));

  assign to_queue = queue_en & tbl_any & ~queue_full;

  always_comb begin
    if (to_queue) begin
      nxt_dest = DEST_QUEUE;
      nxt_idx  = IDXW'(tbl_idx);
    end else if (mb_any) begin
      nxt_dest = DEST_MBOX;
      nxt_idx  = mb_idx;
    end else begin
      nxt_dest = DEST_NONE;
      nxt_idx  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_valid <= 1'b0;
      route_dest  <= DEST_NONE;
      route_idx   <= '0;
    end else begin
      route_valid <= frame_valid;
      if (frame_valid) begin
        route_dest <= nxt_dest;
        route_idx  <= nxt_idx;
      end
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> route_valid);
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> !route_valid);
  p_no_queue_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && !queue_en |=> route_dest != DEST_QUEUE);
  p_low_mb_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && queue_en |=> !(route_dest == DEST_MBOX && int'(route_idx) < TBL));
  p_full_blocks_queue_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && queue_full |=> route_dest != DEST_QUEUE);
  p_winner_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mb_any |-> mb_en[mb_idx] && mb_hit[mb_idx]);
  p_none_idx_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid && route_dest == DEST_NONE |-> route_idx == '0);
endmodule

// File: tb/can_rx_filter_router_tb.sv
module can_rx_filter_router_tb;
  localparam int IDW = 29;
  localparam int NMB = 16;
  localparam int NT  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            frame_valid = 1'b0;
  logic [IDW-1:0]  frame_id = '0;
  logic            frame_ide = 1'b0;
  logic            queue_en = 1'b0, indiv_mask_mode = 1'b0, queue_full = 1'b0;
  logic [IDW-1:0]  glob_mask = '1, mask_a = '1, mask_b = '1;
  logic [IDW-1:0]  im [NMB];
  logic [IDW-1:0]  t_id [NT];
  logic            t_ide [NT];
  logic [IDW-1:0]  m_id [NMB];
  logic            m_ide [NMB];
  logic            m_en [NMB];

  logic [NMB*IDW-1:0] indiv_f, mb_ids_f;
  logic [NT*IDW-1:0]  tbl_ids_f;
  logic [NT-1:0]      tbl_ide_f;
  logic [NMB-1:0]     mb_ide_f, mb_en_f;

  always_comb begin
    for (int k = 0; k < NT; k++) begin
      tbl_ids_f[k*IDW +: IDW] = t_id[k];
      tbl_ide_f[k] = t_ide[k];
    end
    for (int i = 0; i < NMB; i++) begin
      indiv_f[i*IDW +: IDW]  = im[i];
      mb_ids_f[i*IDW +: IDW] = m_id[i];
      mb_ide_f[i] = m_ide[i];
      mb_en_f[i]  = m_en[i];
    end
  end

  logic       route_valid;
  logic [1:0] route_dest;
  logic [3:0] route_idx;

  can_rx_filter_router u_dut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_id(frame_id),
    .frame_ide(frame_ide), .queue_en(queue_en), .indiv_mask_mode(indiv_mask_mode),
    .queue_full(queue_full), .glob_mask(glob_mask), .mask_a(mask_a), .mask_b(mask_b),
    .indiv_masks(indiv_f), .tbl_ids(tbl_ids_f), .tbl_ide(tbl_ide_f),
    .mb_ids(mb_ids_f), .mb_ide(mb_ide_f), .mb_en(mb_en_f),
    .route_valid(route_valid), .route_dest(route_dest), .route_idx(route_idx));

  int n_vec = 0, n_bad = 0, cycles = 0;
  string cur_req = "R1", exp_req = "R1";
  bit exp_v = 1'b0;
  int exp_d = 0, exp_i = 0;

  // behavioural reference: R2 match rule
  function automatic bit hit(logic [IDW-1:0] a, logic [IDW-1:0] b, bit ia, bit ib,
                             logic [IDW-1:0] m);
    if (ia != ib) return 1'b0;
    if (!ia) m = m & 29'h7FF;
    return ((a ^ b) & m) == 0;
  endfunction

  function automatic logic [IDW-1:0] tmask(int k);
    if (indiv_mask_mode) return im[k];     // R6
    if (k == 6) return mask_a;              // R4
    if (k == 7) return mask_b;
    return glob_mask;
  endfunction

  function automatic logic [IDW-1:0] mmask(int i);
    if (indiv_mask_mode) return im[i];     // R6
    if (i == 14) return mask_a;             // R5
    if (i == 15) return mask_b;
    return glob_mask;
  endfunction

  task automatic model(output int d, output int x);
    int qhit = -1;
    int mhit = -1;
    if (queue_en)
      for (int k = NT - 1; k >= 0; k--)
        if (hit(frame_id, t_id[k], frame_ide, t_ide[k], tmask(k))) qhit = k;
    for (int i = NMB - 1; i >= 0; i--)
      if (m_en[i] && !(queue_en && i < NT) &&
          hit(frame_id, m_id[i], frame_ide, m_ide[i], mmask(i))) mhit = i;
    if (qhit >= 0 && !queue_full) begin d = 1; x = qhit; end   // R3, R9
    else if (mhit >= 0) begin d = 2; x = mhit; end              // R10
    else begin d = 0; x = 0; end                                // R11
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) exp_v = 1'b0;
    else begin
      exp_v = frame_valid;
      exp_req = cur_req;
      if (frame_valid) model(exp_d, exp_i);
    end
  end

  always @(negedge clk) begin
    if (cycles > 0) begin
      n_vec++;
      if (route_valid !== exp_v) begin
        n_bad++;
        $display("FAIL %s route_valid act=%b exp=%b", exp_v ? exp_req : "R1",
                 route_valid, exp_v);
      end else if (exp_v && (route_dest !== 2'(exp_d) || route_idx !== 4'(exp_i))) begin
        n_bad++;
        $display("FAIL %s dest/idx act=%0d/%0d exp=%0d/%0d", exp_req,
                 route_dest, route_idx, exp_d, exp_i);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic send(logic [IDW-1:0] id, bit ide, string req);
    @(negedge clk);
    cur_req = req;
    frame_id = id; frame_ide = ide; frame_valid = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    frame_valid = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < NT; k++) begin t_id[k] = 29'(32'h100 + k); t_ide[k] = 1'b0; end
    for (int i = 0; i < NMB; i++) begin
      m_id[i] = 29'(32'h200 + i); m_ide[i] = 1'b0; m_en[i] = 1'b1; im[i] = '1;
    end
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7: queue off, low mailbox reachable, table ignored
    send(29'h203, 1'b0, "R7"); idle();
    send(29'h102, 1'b0, "R7"); idle();
    // R3: queue on, table first even with mailbox match
    queue_en = 1'b1;
    m_id[9] = 29'h102; m_id[11] = 29'h102;
    send(29'h102, 1'b0, "R3"); idle();
    // R8: low mailbox hidden
    send(29'h203, 1'b0, "R8"); idle();
    // R9 and R10: queue full falls back to mailbox, disabled skipped
    queue_full = 1'b1; m_en[9] = 1'b0;
    send(29'h102, 1'b0, "R9"); idle();
    send(29'h105, 1'b0, "R9"); idle();
    queue_full = 1'b0; m_en[9] = 1'b1;
    send(29'h102, 1'b0, "R10"); idle();
    // R4: entry 6 through mask A
    mask_a = 29'h7F0;
    send(29'h10F, 1'b0, "R4"); idle();
    send(29'h107, 1'b0, "R4"); idle();
    // R5: mailbox 14 via mask A beats exact 15
    queue_en = 1'b0; m_id[14] = 29'h2EE; m_id[15] = 29'h2EF;
    send(29'h2EF, 1'b0, "R5"); idle();
    mask_b = 29'h7F0; m_id[15] = 29'h2F5; m_id[14] = 29'h3EE;
    send(29'h2F0, 1'b0, "R5"); idle();
    // R6: individual masks
    indiv_mask_mode = 1'b1; im[12] = '0; m_ide[12] = 1'b1;
    send(29'h1ABCDE, 1'b1, "R6"); idle();
    send(29'h2F0, 1'b0, "R6"); idle();
    indiv_mask_mode = 1'b0; m_ide[12] = 1'b0; im[12] = '1;
    // R2: standard frame ignores upper ID bits; IDE must agree
    m_id[13] = 29'h1000_020D;
    send(29'h20D, 1'b0, "R2"); idle();
    send(29'h20D, 1'b1, "R2"); idle();
    // R11: no match
    send(29'h7FF, 1'b0, "R11"); idle();
    // R1: back-to-back strobes
    send(29'h203, 1'b0, "R1");
    send(29'h204, 1'b0, "R1");
    send(29'h7FF, 1'b0, "R1"); idle();

    // randomized mix around configured IDs
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      cur_req = "R10";
      frame_valid = 1'($urandom_range(0, 1));
      frame_ide = ($urandom_range(0, 7) == 0);
      frame_id = ($urandom_range(0, 1) != 0) ? t_id[$urandom_range(0, NT-1)]
                                             : m_id[$urandom_range(0, NMB-1)];
      frame_id = frame_id ^ 29'($urandom_range(0, 3));
      if (n % 50 == 0) begin
        queue_en = 1'($urandom_range(0, 1));
        indiv_mask_mode = 1'($urandom_range(0, 1));
        glob_mask = ($urandom_range(0, 1) != 0) ? '1 : 29'h1FFFFFFC;
        mask_a = 29'($urandom);
        mask_b = 29'($urandom);
        for (int i = 0; i < NMB; i++) begin
          m_en[i] = ($urandom_range(0, 3) != 0);
          im[i] = ($urandom_range(0, 1) != 0) ? '1 : 29'h1FFFFFFE;
        end
      end
      queue_full = ($urandom_range(0, 3) == 0);
    end
    idle(); idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule